// File: doc/BRIEF.md
# Load-Dependent Valley Skip Counter

This block sets how many ringing zero crossings a quasi-resonant flyback controller lets pass before it switches on again. It holds a saturating skip value between 1 and 7. A light load raises the value, so the converter switches in a later valley and at a lower frequency. A heavier load lowers the value again. The value changes once per slow evaluation period. The change depends on how high the feedback level went at any point during that period.

The feedback level reaches the block as thermometer-coded comparator bits, plus one bit for an emergency reset level. All of these bits are asynchronous and pass through a synchroniser. A pair of line-sense comparator bits selects one of two threshold pairs: one for low line and one for high line. The selection has hysteresis. The skip value drops to 1 at once when the feedback passes the reset level, when the controller starts up, and when the burst-mode controller reports that burst operation has ended.

Top module: `valley_skip_counter`

## Requirements
- R1: The skip value never leaves the range 1 to 7. A step up at 7 leaves it at 7, and a step down at 1 leaves it at 1.
- R2: At a period boundary, the value rises by one if the feedback stayed below the selected up threshold for the whole period.
- R3: At a period boundary, the value is held if the feedback crossed the selected up threshold but not the selected down threshold during the period.
- R4: At a period boundary, the value falls by one if the feedback crossed the selected down threshold at any time in the period.
- R5: A high level on `fbAboveReset` sets the value to 1 within three clock edges, without waiting for a period boundary.
- R6: Asynchronous reset and a `startup` pulse both set the value to 1. `startup` also restarts the evaluation period, so that the next boundary falls `PERIOD_CYCLES` edges later.
- R7: A `burstExit` pulse sets the value to 1 on the next clock edge. The following boundary then acts on the value 1.
- R8: In the low-line set, the up threshold is bit 1 of `fbAbove` (2.5 V) and the down threshold is bit 3 (3.2 V). Bits 0 and 2 have no effect.
- R9: In the high-line set, the up threshold is bit 0 of `fbAbove` (2.3 V) and the down threshold is bit 2 (2.9 V). Bits 1 and 3 have no effect.
- R10: `lineAboveHi` (line current above 1.3 mA) selects the high-line set. `lineBelowLo` (line current below 0.8 mA) selects the low-line set. When neither bit is high, the current selection is kept. Reset selects the low-line set.
- R11: A crossing that lasts a single clock cycle anywhere in the period counts as a crossing in that period.
- R12: Boundaries fall every `PERIOD_CYCLES` clock cycles. Apart from R5 to R7, the value changes only at a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startup | input | 1 | Synchronous start-up pulse: sets the value to 1 and restarts the period |
| burstExit | input | 1 | Synchronous pulse that marks the end of burst operation |
| fbAbove | input | 4 | Asynchronous feedback comparator bits: [0] above 2.3 V, [1] above 2.5 V, [2] above 2.9 V, [3] above 3.2 V |
| fbAboveReset | input | 1 | Asynchronous comparator bit: feedback above 3.9 V |
| lineAboveHi | input | 1 | Asynchronous comparator bit: line current above 1.3 mA |
| lineBelowLo | input | 1 | Asynchronous comparator bit: line current below 0.8 mA |
| skipCount | output | 3 | Number of zero crossings to skip, 1 to 7 |

## Verification
The bench builds the block with `PERIOD_CYCLES` set to 16 in place of the 48 ms default. This allows dozens of evaluation periods, saturation at both ends and both line selections within a few thousand cycles. `MAX_SKIP` keeps its default of 7 and the synchroniser keeps two stages. The bench can therefore place each new feedback pattern so that it reaches the sticky flags exactly at the start of a period. It can also place single-cycle excursions and forced resets in the middle of a period.

// File: rtl/vsk_pkg.sv
package vsk_pkg;

  // Strobes from the control module to the count datapath
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic forceOne;
  } skipCmd_t;

  // Feedback comparator bit positions (thermometer code)
  localparam int FB_BITS    = 4;
  localparam int HI_UP_BIT  = 0;  // 2.3 V
  localparam int LO_UP_BIT  = 1;  // 2.5 V
  localparam int HI_DN_BIT  = 2;  // 2.9 V
  localparam int LO_DN_BIT  = 3;  // 3.2 V

endpackage

// File: rtl/vsk_sync.sv
module vsk_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/vsk_ctrl.sv
module vsk_ctrl
  import vsk_pkg::*;
#(
  parameter int PERIOD_CYCLES = 2400000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startup,
  input  logic               burstExit,
  input  logic [FB_BITS-1:0] fbSync,
  input  logic               rstLevelSync,
  input  logic               lineHiSync,
  input  logic               lineLoSync,
  output skipCmd_t           cmd
);

  localparam int TW = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD_CYCLES - 1);

  logic [TW-1:0]      periodTmr;
  logic               periodTick;
  logic               highLine;
  logic [FB_BITS-1:0] seenAbove;
  logic [FB_BITS-1:0] periodAbove;
  logic               crossedUp;
  logic               crossedDown;

  // Evaluation period timer, restarted by start-up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  periodTmr <= '0;
    else if (startup)           periodTmr <= '0;
    else if (periodTmr == LAST) periodTmr <= '0;
    else                        periodTmr <= periodTmr + 1'b1;
  end

  assign periodTick = (periodTmr == LAST) && !startup;

  // Line threshold set selection with hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           highLine <= 1'b0;
    else if (lineHiSync) highLine <= 1'b1;
    else if (lineLoSync) highLine <= 1'b0;
  end

  // Sticky crossing flags, cleared at every boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      seenAbove <= '0;
    else if (startup || periodTick) seenAbove <= '0;
    else                            seenAbove <= seenAbove | fbSync;
  end

  assign periodAbove = seenAbove | fbSync;

  always_comb begin
    if (highLine) begin
      crossedUp   = periodAbove[HI_UP_BIT];
      crossedDown = periodAbove[HI_DN_BIT];
    end else begin
      crossedUp   = periodAbove[LO_UP_BIT];
      crossedDown = periodAbove[LO_DN_BIT];
    end
  end

  always_comb begin
    cmd.forceOne = startup || burstExit || rstLevelSync;
    cmd.stepDown = periodTick && crossedDown;
    cmd.stepUp   = periodTick && !crossedUp;
  end

endmodule

// File: rtl/vsk_datapath.sv
module vsk_datapath
  import vsk_pkg::*;
#(
  parameter int MAX_SKIP = 7,
  parameter int CW       = $clog2(MAX_SKIP + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  skipCmd_t      cmd,
  output logic [CW-1:0] skipCount
);

  localparam logic [CW-1:0] MIN_VAL = CW'(1);
  localparam logic [CW-1:0] MAX_VAL = CW'(MAX_SKIP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      skipCount <= MIN_VAL;
    else if (cmd.forceOne)
      skipCount <= MIN_VAL;
    else if (cmd.stepDown) begin
      if (skipCount != MIN_VAL) skipCount <= skipCount - 1'b1;
    end else if (cmd.stepUp) begin
      if (skipCount != MAX_VAL) skipCount <= skipCount + 1'b1;
    end
  end

endmodule

// File: rtl/valley_skip_counter.sv
module valley_skip_counter
  import vsk_pkg::*;
#(
  parameter int PERIOD_CYCLES = 2400000,
  parameter int MAX_SKIP      = 7,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              startup,
  input  logic                              burstExit,
  input  logic [3:0]                        fbAbove,
  input  logic                              fbAboveReset,
  input  logic                              lineAboveHi,
  input  logic                              lineBelowLo,
  output logic [$clog2(MAX_SKIP+1)-1:0]     skipCount
);

  localparam int CW = $clog2(MAX_SKIP + 1);
  localparam int SW = FB_BITS + 3;

  logic [SW-1:0]      rawBits;
  logic [SW-1:0]      syncBits;
  logic [FB_BITS-1:0] fbSync;
  logic               rstLevelSync;
  logic               lineHiSync;
  logic               lineLoSync;
  skipCmd_t           cmd;

  assign rawBits = {lineBelowLo, lineAboveHi, fbAboveReset, fbAbove};
  assign {lineLoSync, lineHiSync, rstLevelSync, fbSync} = syncBits;

  vsk_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawBits),
    .syncOut (syncBits)
  );

  vsk_ctrl #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startup      (startup),
    .burstExit    (burstExit),
    .fbSync       (fbSync),
    .rstLevelSync (rstLevelSync),
    .lineHiSync   (lineHiSync),
    .lineLoSync   (lineLoSync),
    .cmd          (cmd)
  );

  vsk_datapath #(.MAX_SKIP(MAX_SKIP), .CW(CW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .skipCount (skipCount)
  );

endmodule

// File: rtl/vsk_checker.sv
module vsk_checker
  import vsk_pkg::*;
#(
  parameter int PERIOD_CYCLES = 2400000,
  parameter int MAX_SKIP      = 7,
  parameter int CW            = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          startup,
  input logic          burstExit,
  input logic          fbAboveReset,
  input skipCmd_t      cmd,
  input logic [CW-1:0] skipCount
);

  localparam int TW = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;

  // Independent phase counter, used to check the boundary window
  logic [TW-1:0] phase;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 phase <= '0;
    else if (startup)                          phase <= '0;
    else if (phase == TW'(PERIOD_CYCLES - 1))  phase <= '0;
    else                                       phase <= phase + 1'b1;
  end

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (skipCount >= CW'(1)) && (skipCount <= CW'(MAX_SKIP))); // R1

  AST_UP_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (skipCount == $past(skipCount) + 1'b1) |-> $past(cmd.stepUp)); // R2

  AST_DOWN_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (skipCount != $past(skipCount) && skipCount != CW'(1)) |-> $past(cmd.stepDown) || $past(cmd.stepUp)); // R4

  AST_RESET_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    $past(fbAboveReset, 2) |=> (skipCount == CW'(1))); // R5

  AST_STARTUP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    startup |=> (skipCount == CW'(1))); // R6

  AST_BURST_ONE: assert property (@(posedge clk) disable iff (!rstN)
    burstExit |=> (skipCount == CW'(1))); // R7

  AST_STEP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepUp || cmd.stepDown) |-> (phase == TW'(PERIOD_CYCLES - 1))); // R12

endmodule

bind valley_skip_counter vsk_checker #(
  .PERIOD_CYCLES (PERIOD_CYCLES),
  .MAX_SKIP      (MAX_SKIP),
  .CW            (CW)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .startup      (startup),
  .burstExit    (burstExit),
  .fbAboveReset (fbAboveReset),
  .cmd          (cmd),
  .skipCount    (skipCount)
);

// File: tb/tb_valley_skip_counter.sv
module tb_valley_skip_counter;

  localparam int P = 16;
  localparam int M = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startup = 1'b0;
  logic       burstExit = 1'b0;
  logic [3:0] fbAbove = 4'b0000;
  logic       fbAboveReset = 1'b0;
  logic       lineAboveHi = 1'b0;
  logic       lineBelowLo = 1'b0;
  logic [2:0] skipCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  valley_skip_counter #(.PERIOD_CYCLES(P), .MAX_SKIP(7), .SYNC_STAGES(2)) dut (
    .clk          (clk),
    .rstN         (rstN),
    .startup      (startup),
    .burstExit    (burstExit),
    .fbAbove      (fbAbove),
    .fbAboveReset (fbAboveReset),
    .lineAboveHi  (lineAboveHi),
    .lineBelowLo  (lineBelowLo),
    .skipCount    (skipCount)
  );

  // Entry: {lineAboveHi, lineBelowLo, fbAbove[3:0], expected[2:0]}
  // Thermometer levels: 0000 <2.3, 0001 2.3-2.5, 0011 2.5-2.9, 0111 2.9-3.2, 1111 3.2-3.9
  localparam int N = 23;
  localparam logic [8:0] VEC [N] = '{
    {2'b00, 4'b0000, 3'd2},  // R2 low line, all below
    {2'b00, 4'b0000, 3'd3},  // R2
    {2'b00, 4'b0001, 3'd4},  // R8 2.3 V bit ignored on low line
    {2'b00, 4'b0011, 3'd4},  // R3 hold
    {2'b00, 4'b0111, 3'd4},  // R8 2.9 V bit ignored on low line
    {2'b00, 4'b1111, 3'd3},  // R4 down
    {2'b00, 4'b0000, 3'd4},
    {2'b00, 4'b0000, 3'd5},
    {2'b00, 4'b0000, 3'd6},
    {2'b00, 4'b0000, 3'd7},
    {2'b00, 4'b0000, 3'd7},  // R1 saturate high
    {2'b00, 4'b1111, 3'd6},
    {2'b10, 4'b0001, 3'd6},  // R9 R10 high line selected: hold above 2.3 V
    {2'b00, 4'b0111, 3'd5},  // R10 selection kept, R9 down above 2.9 V
    {2'b00, 4'b0011, 3'd5},  // R9 hold
    {2'b01, 4'b0111, 3'd5},  // R10 back to low line: 2.9-3.2 V holds
    {2'b00, 4'b0001, 3'd6},  // R8 low line up
    {2'b00, 4'b1111, 3'd5},
    {2'b00, 4'b1111, 3'd4},
    {2'b00, 4'b1111, 3'd3},
    {2'b00, 4'b1111, 3'd2},
    {2'b00, 4'b1111, 3'd1},
    {2'b00, 4'b1111, 3'd1}   // R1 saturate low
  };

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: skipCount=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] pat);
    {lineAboveHi, lineBelowLo, fbAbove} = pat;
  endtask

  // Starts at the negedge after a boundary; ends at the negedge after the next one
  task automatic runPeriod(input logic [5:0] nxt, input logic [2:0] exp, input string tag);
    repeat (P - 2) @(negedge clk);
    drive(nxt);
    repeat (2) @(negedge clk);
    check(skipCount, exp, tag);
  endtask

  // kind: 0 single-cycle excursion, 1 reset level, 2 burst exit
  task automatic injPeriod(input int kind, input logic [5:0] nxt, input logic [2:0] exp, input string tag);
    logic [3:0] keep;
    keep = fbAbove;
    repeat (M) @(negedge clk);
    if (kind == 2) burstExit = 1'b1;
    else begin
      fbAbove = 4'b1111;
      if (kind == 1) fbAboveReset = 1'b1;
    end
    @(negedge clk);
    burstExit = 1'b0;
    fbAboveReset = 1'b0;
    fbAbove = keep;
    repeat (3) @(negedge clk);
    if (kind != 0) check(skipCount, 3'd1, (kind == 1) ? "R5 immediate" : "R7 immediate");
    repeat (P - 6 - M) @(negedge clk);
    drive(nxt);
    repeat (2) @(negedge clk);
    check(skipCount, exp, tag);
  endtask

  function automatic string stepTag(input logic [2:0] prev, input logic [2:0] exp);
    if (exp > prev)      return "R2 table";
    else if (exp < prev) return "R4 table";
    else                 return "R3 table";
  endfunction

  initial begin
    logic [2:0] prev;
    drive(VEC[0][8:3]);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(skipCount, 3'd1, "R6 reset value");

    // Start-up pulse aligns the period (R6, R12)
    startup = 1'b1;
    @(negedge clk);
    startup = 1'b0;

    prev = 3'd1;
    for (int i = 0; i < N; i++) begin
      logic [5:0] nxt;
      nxt = (i < N - 1) ? VEC[i+1][8:3] : 6'b000000;
      runPeriod(nxt, VEC[i][2:0], stepTag(prev, VEC[i][2:0]));
      prev = VEC[i][2:0];
    end

    // Directed: sticky single-cycle excursion (R11)
    runPeriod(6'b000000, 3'd2, "R2 directed");
    runPeriod(6'b000000, 3'd3, "R2 directed");
    injPeriod(0, 6'b000000, 3'd2, "R11 one-cycle crossing");
    // Reset level mid-period (R5)
    injPeriod(1, 6'b000000, 3'd1, "R5 boundary after reset level");
    runPeriod(6'b000000, 3'd2, "R12 next boundary");
    runPeriod(6'b000000, 3'd3, "R12 next boundary");
    // Burst exit mid-period (R7)
    injPeriod(2, 6'b000000, 3'd2, "R7 boundary after burst exit");

    // Start-up mid-period (R6)
    repeat (3) @(negedge clk);
    startup = 1'b1;
    @(negedge clk);
    startup = 1'b0;
    check(skipCount, 3'd1, "R6 startup");
    // Next boundary P edges after the start-up edge
    repeat (P - 2) @(negedge clk);
    check(skipCount, 3'd1, "R12 no change before boundary");
    repeat (2) @(negedge clk);
    check(skipCount, 3'd2, "R12 boundary after startup");

    // Asynchronous reset
    #3 rstN = 1'b0;
    #1 check(skipCount, 3'd1, "R6 async reset");

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: expected=finished actual=hung");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule